// File: doc/BRIEF.md
# Nibble Register File with Pair Access

This block is a bank of sixteen 4-bit general-purpose registers. Two independent ports reach the same storage. The nibble port addresses one register with a 4-bit index. The pair port addresses an 8-bit register pair with a 3-bit index. Pair `p` joins registers `2p` and `2p+1`, and the even register is always the high nibble.

Both ports read combinationally from the stored state. Each port writes on the rising clock edge when its own write enable is high. If both ports write the same register in one cycle, the pair write wins. An active-low asynchronous reset clears every register. The block only stores data and resolves addresses; decoding and arithmetic happen elsewhere.

Top module: `nibble_pair_rf`

## Requirements
- R1: While `rst_ni` is low, every register is 0. After reset, every nibble read and every pair read returns 0.
- R2: With `nib_we_i` high at a rising edge, register `nib_idx_i` takes `nib_wdata_i`.
- R3: `nib_rdata_o` shows register `nib_idx_i` combinationally. A write made at an edge is visible only after that edge.
- R4: `pair_rdata_o` is {register 2·`pair_idx_i`, register 2·`pair_idx_i`+1}. The even register drives bits 7:4 and the odd register drives bits 3:0.
- R5: With `pair_we_i` high at a rising edge, bits 7:4 of `pair_wdata_i` go to register 2·`pair_idx_i` and bits 3:0 go to register 2·`pair_idx_i`+1.
- R6: When both ports write the same register in one cycle, that register takes the pair data.
- R7: With both write enables low, no register changes.
- R8: A nibble write changes only its own register. When the two ports write different registers in one cycle, both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nib_we_i | input | 1 | Nibble port write enable |
| nib_idx_i | input | 4 | Nibble port register index |
| nib_wdata_i | input | 4 | Nibble port write data |
| nib_rdata_o | output | 4 | Nibble port read data |
| pair_we_i | input | 1 | Pair port write enable |
| pair_idx_i | input | 3 | Pair port index |
| pair_wdata_i | input | 8 | Pair port write data: high nibble to even register |
| pair_rdata_o | output | 8 | Pair port read data: even register in bits 7:4 |

## Verification
The bench builds the block with its default parameters: sixteen 4-bit registers and eight pairs. With only sixteen registers, random indices hit each register and each pair many times. Random traffic therefore often puts both ports on the same pair, and often on the very same register. That lets same-cycle collisions, both-port writes to neighbouring registers, and read-before-write timing all appear next to the directed cases for reset, index 0 and index 15.

// File: rtl/nrf_pkg.sv
package nrf_pkg;
  parameter int unsigned NRF_NIB_W    = 4;
  parameter int unsigned NRF_NUM_REGS = 16;
endpackage

// File: rtl/nrf_wr_dec.sv
module nrf_wr_dec #(
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned PIDX_W  = IDX_W - 1
) (
  input  logic                nib_we_i,
  input  logic [IDX_W-1:0]    nib_idx_i,
  input  logic                pair_we_i,
  input  logic [PIDX_W-1:0]   pair_idx_i,
  output logic [NUM_REGS-1:0] nib_hit_o,
  output logic [NUM_REGS-1:0] pair_hit_o
);
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
    localparam logic [IDX_W-1:0]  KI = IDX_W'(k);
    localparam logic [PIDX_W-1:0] KP = PIDX_W'(k / 2);
    assign pair_hit_o[k] = pair_we_i && (pair_idx_i == KP);
    // pair port owns the register on collision
    assign nib_hit_o[k]  = nib_we_i && (nib_idx_i == KI) && !pair_hit_o[k];
  end
endmodule

// File: rtl/nrf_cell.sv
module nrf_cell #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         nib_en_i,
  input  logic [W-1:0] nib_d_i,
  input  logic         pair_en_i,
  input  logic [W-1:0] pair_d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        q_o <= '0;
    else if (pair_en_i) q_o <= pair_d_i;
    else if (nib_en_i)  q_o <= nib_d_i;
  end
endmodule

// File: rtl/nrf_rd_mux.sv
module nrf_rd_mux #(
  parameter int unsigned W        = 4,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned PIDX_W  = IDX_W - 1
) (
  input  logic [NUM_REGS*W-1:0] regs_i,
  input  logic [IDX_W-1:0]      nib_idx_i,
  input  logic [PIDX_W-1:0]     pair_idx_i,
  output logic [W-1:0]          nib_rdata_o,
  output logic [2*W-1:0]        pair_rdata_o
);
  logic [IDX_W-1:0] even_idx, odd_idx;

  assign even_idx = {pair_idx_i, 1'b0};
  assign odd_idx  = {pair_idx_i, 1'b1};

  assign nib_rdata_o  = regs_i[nib_idx_i*W +: W];
  assign pair_rdata_o = {regs_i[even_idx*W +: W], regs_i[odd_idx*W +: W]};
endmodule

// File: rtl/nibble_pair_rf.sv
module nibble_pair_rf
  import nrf_pkg::*;
#(
  parameter int unsigned NIB_W    = NRF_NIB_W,
  parameter int unsigned NUM_REGS = NRF_NUM_REGS,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned PIDX_W  = IDX_W - 1,
  localparam int unsigned PAIR_W  = 2 * NIB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              nib_we_i,
  input  logic [IDX_W-1:0]  nib_idx_i,
  input  logic [NIB_W-1:0]  nib_wdata_i,
  output logic [NIB_W-1:0]  nib_rdata_o,
  input  logic              pair_we_i,
  input  logic [PIDX_W-1:0] pair_idx_i,
  input  logic [PAIR_W-1:0] pair_wdata_i,
  output logic [PAIR_W-1:0] pair_rdata_o
);
  logic [NUM_REGS-1:0]       nib_hit, pair_hit;
  logic [NUM_REGS*NIB_W-1:0] regs_flat;

  nrf_wr_dec #(.NUM_REGS(NUM_REGS)) i_dec (
    .nib_we_i   (nib_we_i),
    .nib_idx_i  (nib_idx_i),
    .pair_we_i  (pair_we_i),
    .pair_idx_i (pair_idx_i),
    .nib_hit_o  (nib_hit),
    .pair_hit_o (pair_hit)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
    // even register takes the high half of pair data
    localparam int unsigned LO = (k % 2 == 0) ? NIB_W : 0;
    nrf_cell #(.W(NIB_W)) i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .nib_en_i  (nib_hit[k]),
      .nib_d_i   (nib_wdata_i),
      .pair_en_i (pair_hit[k]),
      .pair_d_i  (pair_wdata_i[LO +: NIB_W]),
      .q_o       (regs_flat[k*NIB_W +: NIB_W])
    );
  end

  nrf_rd_mux #(.W(NIB_W), .NUM_REGS(NUM_REGS)) i_rd (
    .regs_i       (regs_flat),
    .nib_idx_i    (nib_idx_i),
    .pair_idx_i   (pair_idx_i),
    .nib_rdata_o  (nib_rdata_o),
    .pair_rdata_o (pair_rdata_o)
  );
endmodule

// File: rtl/nibble_pair_rf_chk.sv
module nibble_pair_rf_chk #(
  parameter int unsigned NIB_W    = 4,
  parameter int unsigned NUM_REGS = 16,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS),
  localparam int unsigned PIDX_W  = IDX_W - 1,
  localparam int unsigned PAIR_W  = 2 * NIB_W
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      nib_we_i,
  input logic [IDX_W-1:0]          nib_idx_i,
  input logic [NIB_W-1:0]          nib_wdata_i,
  input logic [NIB_W-1:0]          nib_rdata_o,
  input logic                      pair_we_i,
  input logic [PIDX_W-1:0]         pair_idx_i,
  input logic [PAIR_W-1:0]         pair_wdata_i,
  input logic [NUM_REGS*NIB_W-1:0] regs_flat
);
  // R1
  reset_clear_chk: assert property (@(posedge clk_i)
    !rst_ni |=> (regs_flat == '0));

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nib_we_i && !pair_we_i) |=> $stable(regs_flat));

  // R2
  nib_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nib_we_i && !(pair_we_i && nib_idx_i[IDX_W-1:1] == pair_idx_i))
    |=> (regs_flat[$past(nib_idx_i)*NIB_W +: NIB_W] == $past(nib_wdata_i)));

  // R5
  pair_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_we_i |=> (regs_flat[{$past(pair_idx_i), 1'b0}*NIB_W +: NIB_W]
                   == $past(pair_wdata_i[PAIR_W-1:NIB_W])));

  // R5
  pair_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pair_we_i |=> (regs_flat[{$past(pair_idx_i), 1'b1}*NIB_W +: NIB_W]
                   == $past(pair_wdata_i[NIB_W-1:0])));

  // R3
  nib_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_rdata_o == regs_flat[nib_idx_i*NIB_W +: NIB_W]);
endmodule

bind nibble_pair_rf nibble_pair_rf_chk #(.NIB_W(NIB_W), .NUM_REGS(NUM_REGS)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .nib_we_i     (nib_we_i),
  .nib_idx_i    (nib_idx_i),
  .nib_wdata_i  (nib_wdata_i),
  .nib_rdata_o  (nib_rdata_o),
  .pair_we_i    (pair_we_i),
  .pair_idx_i   (pair_idx_i),
  .pair_wdata_i (pair_wdata_i),
  .regs_flat    (regs_flat)
);

// File: tb/test_nibble_pair_rf.sv
`timescale 1ns/1ps
module test_nibble_pair_rf;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       nib_we_i = 1'b0;
  logic [3:0] nib_idx_i = '0;
  logic [3:0] nib_wdata_i = '0;
  logic [3:0] nib_rdata_o;
  logic       pair_we_i = 1'b0;
  logic [2:0] pair_idx_i = '0;
  logic [7:0] pair_wdata_i = '0;
  logic [7:0] pair_rdata_o;

  int checks = 0;
  int fails  = 0;
  logic [3:0] model [16];

  always #2.5 clk_i = ~clk_i;

  nibble_pair_rf i_nibble_pair_rf (.*);

  function automatic logic [7:0] exp_pair(input logic [2:0] p);
    return {model[{p, 1'b0}], model[{p, 1'b1}]};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, check pre-write reads, update model after edge
  task automatic step(input logic nwe, input logic [3:0] ni, input logic [3:0] nd,
                      input logic pwe, input logic [2:0] pi, input logic [7:0] pd,
                      input string req);
    @(negedge clk_i);
    nib_we_i = nwe; nib_idx_i = ni; nib_wdata_i = nd;
    pair_we_i = pwe; pair_idx_i = pi; pair_wdata_i = pd;
    #1;
    chk({req, " R3 pre-write nib"}, {4'h0, nib_rdata_o}, {4'h0, model[ni]});
    chk({req, " R4 pre-write pair"}, pair_rdata_o, exp_pair(pi));
    @(posedge clk_i);
    if (nwe) model[ni] = nd;
    if (pwe) begin
      model[{pi, 1'b0}] = pd[7:4];
      model[{pi, 1'b1}] = pd[3:0];
    end
    #0.5;
    nib_we_i = 1'b0; pair_we_i = 1'b0;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk_i);
      nib_we_i = 1'b0; pair_we_i = 1'b0;
      nib_idx_i = 4'(i); pair_idx_i = 3'(i / 2);
      #1;
      chk({req, " nib"}, {4'h0, nib_rdata_o}, {4'h0, model[i]});
      chk({req, " R4 pair"}, pair_rdata_o, exp_pair(3'(i / 2)));
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) model[i] = 4'h0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    sweep("R1 reset");

    // R2 edge indices
    step(1, 4'd0, 4'hA, 0, 3'd0, 8'h00, "R2");
    step(1, 4'd15, 4'h5, 0, 3'd0, 8'h00, "R2");
    sweep("R2/R8 after nib writes");

    // R5 pair writes at both ends
    step(0, 4'd0, 4'h0, 1, 3'd0, 8'h3C, "R5");
    step(0, 4'd0, 4'h0, 1, 3'd7, 8'hE1, "R5");
    sweep("R5 after pair writes");

    // R6 collision on even and on odd register
    step(1, 4'd6, 4'hF, 1, 3'd3, 8'h12, "R6 even");
    step(1, 4'd9, 4'h7, 1, 3'd4, 8'h9B, "R6 odd");
    sweep("R6 collision");

    // R8 both ports to different registers
    step(1, 4'd2, 4'h4, 1, 3'd5, 8'h68, "R8");
    sweep("R8 both write");

    // R7 idle: data presented but enables low
    step(0, 4'd3, 4'hF, 0, 3'd1, 8'hFF, "R7");
    sweep("R7 idle");

    // random traffic, pair and nibble often overlap
    for (int n = 0; n < 400; n++) begin
      logic [3:0] ri;
      logic [2:0] rp;
      ri = 4'($urandom);
      rp = ($urandom % 4 == 0) ? ri[3:1] : 3'($urandom);
      step(1'($urandom), ri, 4'($urandom), 1'($urandom), rp, 8'($urandom), "R6/R8 random");
    end
    sweep("R2/R5 random final");

    // R1 reset mid-run
    @(negedge clk_i) rst_ni = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = 4'h0;
    #1;
    chk("R1 async clear", pair_rdata_o, 8'h00);
    @(negedge clk_i) rst_ni = 1'b1;
    sweep("R1 re-reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule